// File: doc/BRIEF.md
# Serial Bus Node Control/Status Register Unit

This unit keeps the small set of node control and status registers that a serial bus node has to answer for on the bus. It has a node state word with three live flags: cycle-master, abdicate and request-disable. Software sets and clears these flags through separate set and clear write selects. The unit also holds a split-transaction timeout as a seconds part and a bus-cycle part. From them it presents a combined timeout in bus cycles to the rest of the node, and it answers reads of a fixed capabilities word.

The unit tracks whether the node was root at the previous bus reset. On every bus-reset pulse it uses that history, together with the current root flag and the cycle-master-capable flag, to decide the cycle-master flag and a registered cycle-start enable. Accesses use a single select, a write strobe and a 32-bit data bus. Read data follows the select combinationally. A resume pulse puts the register contents back to their initial settings.

Top module: `bus_node_csr_unit`

## Requirements
- R1: The state word keeps only bit 12 (request-disable), bit 10 (abdicate) and bit 8 (cycle-master). Every other bit reads 0. A write to select 1 ORs the masked data into the word, and a write to select 2 clears the masked data bits. Selects 0, 1 and 2 all read the state word.
- R2: A set write (select 1) with data bit 8 high while is_root is high drives cycle_start_en high one clock later. The same write while not root leaves cycle_start_en unchanged.
- R3: A clear write (select 2) with data bit 8 high while is_root is high drives cycle_start_en low one clock later. The same write while not root leaves cycle_start_en unchanged.
- R4: A write to select 3 stores data bits [2:0] as the seconds part and ignores all other bits. A read of select 3 returns the stored value in bits [2:0] with zeros above.
- R5: The cycle part travels in bits [31:19]. A write to select 4 takes data bits [31:19] and ignores bits [18:0]. A read of select 4 returns the stored value in bits [31:19] with zeros below.
- R6: After the shift, a written cycle part is clamped to the range 800 to 7999 inclusive.
- R7: split_timeout always equals seconds × 8000 + cycle part, and it reflects a write on the clock after that write.
- R8: A read of select 5 returns 0x000083C0. Selects 6 and 7 read 0, and writes to selects 0, 5, 6 and 7 change nothing.
- R9: Every bus reset clears abdicate. If is_root is low, the bus reset also clears cycle-master and the was-root history, and cycle_start_en keeps its value.
- R10: On a bus reset with is_root high and no root history, the history is set, and cycle-master and cycle_start_en both take the value of cm_capable.
- R11: On a bus reset with is_root high and root history already set, cycle-master and cycle_start_en keep their values.
- R12: After reset the seconds part is 0, the cycle part is 800, the state word is 0, the history is clear and cycle_start_en is 0. A resume pulse restores the same register values but leaves cycle_start_en untouched.
- R13: In one cycle, resume overrides any write and any bus reset. A write and a bus reset in the same cycle act as the write followed by the bus-reset processing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resume | input | 1 | Pulse that restores the initial register contents |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | Access is a write when high |
| acc_sel | input | 3 | Register select: 0 state, 1 set, 2 clear, 3 seconds, 4 cycles, 5 capabilities |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the current select |
| is_root | input | 1 | Node is currently root on the bus |
| cm_capable | input | 1 | Node can act as cycle master |
| bus_reset | input | 1 | One-cycle bus-reset pulse |
| split_timeout | output | 16 | Combined split timeout in bus cycles |
| cycle_start_en | output | 1 | Registered cycle-start generation enable |

## Verification
The hardest case to reach is the root-history path. A bus reset that leaves cycle-master alone needs the node to have been root at the previous bus reset, and also needs the flag to have been changed since then by a root-side clear write. The stimulus therefore chains bus resets in the order non-root, first-root with capability, clear under root, root again, and then repeats the chain with capability low. After that comes a long random phase in which bus resets, root changes, resumes and writes collide in the same cycle. A behavioural model checks the results on every clock.

// File: rtl/node_csr_pkg.sv
package node_csr_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_STATE = 3'd0,
    SEL_SET   = 3'd1,
    SEL_CLR   = 3'd2,
    SEL_TO_HI = 3'd3,
    SEL_TO_LO = 3'd4,
    SEL_CAPS  = 3'd5
  } csr_sel_e;

endpackage

// File: rtl/csr_state_ctrl.sv
module csr_state_ctrl #(
  parameter int unsigned WORD_W       = 32,
  parameter int unsigned CMSTR_BIT    = 8,
  parameter int unsigned ABDICATE_BIT = 10,
  parameter int unsigned DREQ_BIT     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resume,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic              is_root,
  input  logic              cm_capable,
  input  logic              bus_reset,
  output logic [WORD_W-1:0] state_o,
  output logic              cyc_start_en_o
);

  localparam logic [WORD_W-1:0] CM_MASK  = WORD_W'(1) << CMSTR_BIT;
  localparam logic [WORD_W-1:0] ABD_MASK = WORD_W'(1) << ABDICATE_BIT;
  localparam logic [WORD_W-1:0] DRQ_MASK = WORD_W'(1) << DREQ_BIT;
  localparam logic [WORD_W-1:0] KEEP    = CM_MASK | ABD_MASK | DRQ_MASK;

  logic [WORD_W-1:0] st_q, st_d;
  logic              was_root_q, was_root_d;
  logic              en_q, en_d;
  logic              upd;

  assign upd = resume | set_we | clr_we | bus_reset;

  always_comb begin
    st_d       = st_q;
    was_root_d = was_root_q;
    en_d       = en_q;
    if (resume) begin
      st_d       = '0;
      was_root_d = 1'b0;
    end else begin
      if (set_we) begin
        st_d = st_d | (wdata & KEEP);
        if (wdata[CMSTR_BIT] && is_root) en_d = 1'b1;
      end
      if (clr_we) begin
        st_d = st_d & ~(wdata & KEEP);
        if (wdata[CMSTR_BIT] && is_root) en_d = 1'b0;
      end
      if (bus_reset) begin
        st_d = st_d & ~ABD_MASK;
        if (!is_root) begin
          was_root_d = 1'b0;
          st_d       = st_d & ~CM_MASK;
        end else if (!was_root_q) begin
          was_root_d = 1'b1;
          en_d       = cm_capable;
          if (cm_capable) st_d = st_d | CM_MASK;
          else            st_d = st_d & ~CM_MASK;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= '0;
      was_root_q <= 1'b0;
      en_q       <= 1'b0;
    end else if (upd) begin
      st_q       <= st_d;
      was_root_q <= was_root_d;
      en_q       <= en_d;
    end
  end

  assign state_o        = st_q;
  assign cyc_start_en_o = en_q;

  // R9
  abd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !state_o[ABDICATE_BIT]);

  // R9
  nonroot_cm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !is_root) |=> !state_o[CMSTR_BIT]);

  // R2
  cs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && wdata[CMSTR_BIT] && is_root && !resume && !bus_reset) |=> cyc_start_en_o);

  // R3
  cs_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && wdata[CMSTR_BIT] && is_root && !resume && !bus_reset) |=> !cyc_start_en_o);

  // R10
  first_root_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && is_root && !was_root_q && !resume)
      |=> (state_o[CMSTR_BIT] == $past(cm_capable)) && (cyc_start_en_o == $past(cm_capable)));

  // R11
  root_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && is_root && was_root_q && !resume && !set_we && !clr_we)
      |=> $stable(state_o[CMSTR_BIT]) && $stable(cyc_start_en_o));

endmodule

// File: rtl/csr_split_timeout.sv
module csr_split_timeout #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned HI_W    = 3,
  parameter int unsigned LO_W    = 13,
  parameter int unsigned CPS     = 8000,
  parameter int unsigned LO_MIN  = 800,
  parameter int unsigned LO_MAX  = 7999,
  parameter int unsigned LO_INIT = 800,
  parameter int unsigned TOTAL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               resume,
  input  logic               hi_we,
  input  logic               lo_we,
  input  logic [WORD_W-1:0]  wdata,
  output logic [HI_W-1:0]    hi_o,
  output logic [LO_W-1:0]    lo_o,
  output logic [TOTAL_W-1:0] total_o
);

  localparam int unsigned LO_SHIFT = WORD_W - LO_W;
  localparam logic [LO_W-1:0] LO_MIN_V  = LO_W'(LO_MIN);
  localparam logic [LO_W-1:0] LO_MAX_V  = LO_W'(LO_MAX);
  localparam logic [LO_W-1:0] LO_INIT_V = LO_W'(LO_INIT);

  logic [HI_W-1:0] hi_q, hi_d;
  logic [LO_W-1:0] lo_q, lo_d;
  logic [LO_W-1:0] lo_shifted;
  logic            upd;

  assign lo_shifted = wdata[WORD_W-1:LO_SHIFT];
  assign upd        = resume | hi_we | lo_we;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (resume) begin
      hi_d = '0;
      lo_d = LO_INIT_V;
    end else begin
      if (hi_we) hi_d = wdata[HI_W-1:0];
      if (lo_we) begin
        if (lo_shifted < LO_MIN_V)      lo_d = LO_MIN_V;
        else if (lo_shifted > LO_MAX_V) lo_d = LO_MAX_V;
        else                            lo_d = lo_shifted;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= LO_INIT_V;
    end else if (upd) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_o    = hi_q;
  assign lo_o    = lo_q;
  assign total_o = TOTAL_W'(hi_q) * TOTAL_W'(CPS) + TOTAL_W'(lo_q);

  // R6
  lo_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we && !resume) |=> (lo_o >= LO_MIN_V) && (lo_o <= LO_MAX_V));

  // R4
  hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !resume) |=> hi_o == $past(wdata[HI_W-1:0]));

  // R12
  resume_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> (hi_o == '0) && (lo_o == LO_INIT_V));

endmodule

// File: rtl/bus_node_csr_unit.sv
module bus_node_csr_unit #(
  parameter int unsigned CMSTR_BIT      = 8,
  parameter int unsigned ABDICATE_BIT   = 10,
  parameter int unsigned DREQ_BIT       = 12,
  parameter int unsigned HI_W           = 3,
  parameter int unsigned LO_W           = 13,
  parameter int unsigned CYCLES_PER_SEC = 8000,
  parameter int unsigned LO_MIN         = 800,
  parameter int unsigned LO_MAX         = 7999,
  parameter int unsigned LO_INIT        = 800,
  parameter logic [31:0] CAPS_WORD      = 32'h0000_83C0,
  localparam int unsigned TOTAL_W =
    $clog2(((1 << HI_W) - 1) * CYCLES_PER_SEC + LO_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               resume,
  input  logic               acc_en,
  input  logic               acc_wr,
  input  logic [2:0]         acc_sel,
  input  logic [31:0]        acc_wdata,
  output logic [31:0]        acc_rdata,
  input  logic               is_root,
  input  logic               cm_capable,
  input  logic               bus_reset,
  output logic [TOTAL_W-1:0] split_timeout,
  output logic               cycle_start_en
);

  import node_csr_pkg::*;

  localparam logic [WORD_W-1:0] KEEP = (WORD_W'(1) << CMSTR_BIT)
                                     | (WORD_W'(1) << ABDICATE_BIT)
                                     | (WORD_W'(1) << DREQ_BIT);

  csr_sel_e          sel;
  logic              wr_go;
  logic              set_we, clr_we, hi_we, lo_we;
  logic [WORD_W-1:0] state_w;
  logic [HI_W-1:0]   hi_w;
  logic [LO_W-1:0]   lo_w;

  assign sel    = csr_sel_e'(acc_sel);
  assign wr_go  = acc_en & acc_wr;
  assign set_we = wr_go && (sel == SEL_SET);
  assign clr_we = wr_go && (sel == SEL_CLR);
  assign hi_we  = wr_go && (sel == SEL_TO_HI);
  assign lo_we  = wr_go && (sel == SEL_TO_LO);

  csr_state_ctrl #(
    .WORD_W      (WORD_W),
    .CMSTR_BIT   (CMSTR_BIT),
    .ABDICATE_BIT(ABDICATE_BIT),
    .DREQ_BIT    (DREQ_BIT)
  ) u_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .resume        (resume),
    .set_we        (set_we),
    .clr_we        (clr_we),
    .wdata         (acc_wdata),
    .is_root       (is_root),
    .cm_capable    (cm_capable),
    .bus_reset     (bus_reset),
    .state_o       (state_w),
    .cyc_start_en_o(cycle_start_en)
  );

  csr_split_timeout #(
    .WORD_W (WORD_W),
    .HI_W   (HI_W),
    .LO_W   (LO_W),
    .CPS    (CYCLES_PER_SEC),
    .LO_MIN (LO_MIN),
    .LO_MAX (LO_MAX),
    .LO_INIT(LO_INIT),
    .TOTAL_W(TOTAL_W)
  ) u_split (
    .clk    (clk),
    .rst_n  (rst_n),
    .resume (resume),
    .hi_we  (hi_we),
    .lo_we  (lo_we),
    .wdata  (acc_wdata),
    .hi_o   (hi_w),
    .lo_o   (lo_w),
    .total_o(split_timeout)
  );

  always_comb begin
    acc_rdata = '0;
    case (sel)
      SEL_STATE, SEL_SET, SEL_CLR: acc_rdata = state_w;
      SEL_TO_HI: acc_rdata = {{(WORD_W-HI_W){1'b0}}, hi_w};
      SEL_TO_LO: acc_rdata = {lo_w, {(WORD_W-LO_W){1'b0}}};
      SEL_CAPS:  acc_rdata = CAPS_WORD;
      default:   acc_rdata = '0;
    endcase
  end

  // R1
  state_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_STATE) |-> ((acc_rdata & ~KEEP) == '0));

  // R5
  lo_read_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_TO_LO) |-> (acc_rdata[WORD_W-LO_W-1:0] == '0));

  // R8
  caps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CAPS) |-> (acc_rdata == CAPS_WORD));

endmodule

// File: tb/bus_node_csr_unit_tb_top.sv
`timescale 1ns/1ps
module bus_node_csr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        resume, acc_en, acc_wr, is_root, cm_capable, bus_reset;
  logic [2:0]  acc_sel;
  logic [31:0] acc_wdata, acc_rdata;
  logic [15:0] split_timeout;
  logic        cycle_start_en;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  int unsigned m_state, m_hi, m_lo;
  bit          m_was, m_en;

  always #2 clk = ~clk;

  bus_node_csr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .resume(resume), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .is_root(is_root), .cm_capable(cm_capable), .bus_reset(bus_reset),
    .split_timeout(split_timeout), .cycle_start_en(cycle_start_en)
  );

  localparam int unsigned CM  = 32'h0000_0100;
  localparam int unsigned ABD = 32'h0000_0400;
  localparam int unsigned DRQ = 32'h0000_1000;
  localparam int unsigned MSK = CM | ABD | DRQ;

  function automatic int unsigned model_read(input int unsigned s);
    case (s)
      0, 1, 2: return m_state;
      3:       return m_hi;
      4:       return m_lo << 19;
      5:       return 32'h0000_83C0;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int unsigned w, sh;
    if (resume) begin
      m_hi = 0; m_lo = 800; m_state = 0; m_was = 0;
      return;
    end
    w = acc_wdata;
    if (acc_en && acc_wr) begin
      case (acc_sel)
        3'd1: begin m_state |= (w & MSK); if ((w & CM) != 0 && is_root) m_en = 1; end
        3'd2: begin m_state &= ~(w & MSK); if ((w & CM) != 0 && is_root) m_en = 0; end
        3'd3: m_hi = w & 7;
        3'd4: begin
          sh = w >> 19;
          m_lo = (sh < 800) ? 800 : ((sh > 7999) ? 7999 : sh);
        end
        default: ;
      endcase
    end
    if (bus_reset) begin
      m_state &= ~ABD;
      if (!is_root) begin
        m_was = 0; m_state &= ~CM;
      end else if (!m_was) begin
        m_was = 1;
        m_en  = cm_capable;
        if (cm_capable) m_state |= CM; else m_state &= ~CM;
      end
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "rdata", acc_rdata, model_read(acc_sel));
    check(tag, "split_timeout", split_timeout, m_hi * 8000 + m_lo);
    check(tag, "cycle_start_en", cycle_start_en, m_en);
  endtask

  // called at a negedge: drive, take the edge, compare at the next negedge
  task automatic step(input string tag, input bit en, input bit wr, input logic [2:0] sel,
                      input logic [31:0] wd, input bit root, input bit cap,
                      input bit brst, input bit res);
    acc_en = en; acc_wr = wr; acc_sel = sel; acc_wdata = wd;
    is_root = root; cm_capable = cap; bus_reset = brst; resume = res;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic rd(input string tag, input logic [2:0] sel, input bit root);
    step(tag, 1'b1, 1'b0, sel, 32'h0, root, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic wr(input string tag, input logic [2:0] sel, input logic [31:0] wd, input bit root);
    step(tag, 1'b1, 1'b1, sel, wd, root, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic brst(input string tag, input bit root, input bit cap);
    step(tag, 1'b0, 1'b0, 3'd0, 32'h0, root, cap, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; resume = 0; acc_en = 0; acc_wr = 0; acc_sel = 3'd4;
    acc_wdata = 0; is_root = 0; cm_capable = 1; bus_reset = 0;
    m_state = 0; m_hi = 0; m_lo = 800; m_was = 0; m_en = 0;
    repeat (3) @(negedge clk);
    // R12 reset values observed while reset is held
    check("R12", "reset lo read", acc_rdata, 800 << 19);
    check("R12", "reset total", split_timeout, 800);
    check("R12", "reset enable", cycle_start_en, 0);
    rst_n = 1'b1;
    rd("R12", 3'd0, 0);
    rd("R8", 3'd5, 0);
    rd("R8", 3'd6, 0);
    wr("R8", 3'd5, 32'hFFFF_FFFF, 0);
    wr("R8", 3'd7, 32'hFFFF_FFFF, 0);
    wr("R8", 3'd0, 32'hFFFF_FFFF, 0);
    rd("R8", 3'd0, 0);

    // R1 masking, R2 non-root set leaves enable low
    wr("R1", 3'd1, 32'hFFFF_FFFF, 0);
    check("R2", "non-root set enable", cycle_start_en, 0);
    wr("R1", 3'd2, CM, 0);
    check("R1", "state after clear", acc_rdata, ABD | DRQ);
    wr("R1", 3'd2, 32'hFFFF_EFFF, 0);
    rd("R1", 3'd0, 0);

    // R2 / R3 root-side enable control
    wr("R2", 3'd1, CM, 1);
    check("R2", "root set enable", cycle_start_en, 1);
    wr("R3", 3'd2, CM, 0);
    check("R3", "non-root clear keeps enable", cycle_start_en, 1);
    wr("R3", 3'd2, CM, 1);
    check("R3", "root clear enable", cycle_start_en, 0);

    // R4 seconds part
    wr("R4", 3'd3, 32'hFFFF_FFFD, 0);
    check("R4", "hi read", acc_rdata, 5);
    // R5 / R6 / R7 cycle part
    wr("R5", 3'd4, (1000 << 19) | 32'h7FFFF, 0);
    check("R7", "total", split_timeout, 5 * 8000 + 1000);
    wr("R6", 3'd4, 10 << 19, 0);
    wr("R6", 3'd4, 799 << 19, 0);
    wr("R6", 3'd4, 800 << 19, 0);
    wr("R6", 3'd4, 32'hFFFF_FFFF, 0);
    check("R6", "clamp high", acc_rdata, 7999 << 19);
    wr("R6", 3'd4, 8000 << 19, 0);
    wr("R6", 3'd4, 7998 << 19, 0);
    wr("R7", 3'd3, 7, 0);
    check("R7", "max-ish total", split_timeout, 7 * 8000 + 7998);

    // R9 .. R11 bus reset history
    wr("R9", 3'd1, ABD | CM, 0);
    brst("R9", 0, 1);
    rd("R9", 3'd0, 0);
    brst("R10", 1, 1);
    rd("R10", 3'd0, 1);
    check("R10", "first root enable", cycle_start_en, 1);
    wr("R11", 3'd2, CM, 1);
    brst("R11", 1, 1);
    rd("R11", 3'd0, 1);
    check("R11", "held enable", cycle_start_en, 0);
    brst("R9", 0, 1);
    wr("R2", 3'd1, CM, 1);
    brst("R10", 1, 0);
    check("R10", "incapable root enable", cycle_start_en, 0);
    rd("R10", 3'd0, 1);

    // R13 same-cycle interactions
    step("R13", 1, 1, 3'd1, ABD | DRQ, 1, 1, 1, 0);
    step("R13", 1, 1, 3'd3, 32'h6, 1, 1, 1, 1);
    check("R13", "resume beats write", split_timeout, 800);
    wr("R2", 3'd1, CM, 1);
    // R12 resume keeps enable
    step("R12", 1, 0, 3'd0, 0, 1, 1, 0, 1);
    check("R12", "resume keeps enable", cycle_start_en, 1);

    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] d;
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = ($urandom_range(0, 8191) << 19) | ($urandom() & 32'h7FFFF);
      step("R13", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 3'($urandom_range(0, 7)),
           d, $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 30) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule